// File: doc/BRIEF.md
# Cold/Warm Reset Combiner

This block gathers a set of reset request lines and produces two active-low reset outputs for the rest of the chip. The cold output follows only the cold requests: power-on, power-domain power-up and an eFuse programming failure. The combined output follows every request, cold or warm. The warm requests are a software request, a watchdog timeout, an external reset pin and a debug request. Both outputs drop the moment a qualifying request rises, with no clock involved. The release is resynchronised to the module clock by a two-stage synchroniser and then held off by a programmable number of cycles.

The combined output treats a low cold output as one more request. A cold event therefore always releases the cold output first and the combined output after that, each with its own hold-off. A sticky status register records which requests have occurred. Software clears bits by writing ones to them. The two 8-bit hold-off lengths sit in a small register file that only a cold reset returns to its defaults. A warm reset keeps the values that software has programmed.

Top module: `rst_combiner`

## Requirements
- R1: While the power-on request (cold_req[0]) is high, both outputs are low. After it falls between clock edges, rst_cold_n goes high on the 6th rising edge and rst_warm_n goes high on the 10th rising edge. These counts follow from the default lengths of 4 (cold) and 2 (warm).
- R2: A cold request (any bit of cold_req) drives both outputs low at once, without waiting for a clock edge. After a cold request, both hold-off lengths read back their defaults of 4 and 2.
- R3: A warm request (any bit of warm_req) drives rst_warm_n low at once and leaves rst_cold_n high throughout.
- R4: When the last warm request falls between clock edges, rst_warm_n goes high on rising edge number E+2, where E is the programmed warm length. A programmed value of 0 counts as E=1. rst_warm_n never goes high while rst_cold_n is low.
- R5: If a request rises again while a release is being held off, the hold-off restarts. The full count is measured from the new falling edge.
- R6: Address 0 reads the status register. Bit i is cold request i (bits 0 to 2), and bit 3+j is warm request j (bits 3 to 6). Bits are sticky. The debug request (warm_req[3], bit 6) is not logged and reads 0.
- R7: Writing to address 0 clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R8: A cold request clears every warm status bit and sets its own bit. The power-on request leaves only bit 0 set, so the register reads 0x01.
- R9: Address 1 holds the cold length and address 2 holds the warm length, each 8 bits. Their defaults are 4 and 2. A warm reset keeps their values. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| cold_req | input | 3 | Active-high cold requests: 0 power-on, 1 domain power-up, 2 eFuse failure |
| warm_req | input | 4 | Active-high warm requests: 0 software, 1 watchdog, 2 external pin, 3 debug |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| rst_cold_n | output | 1 | Active-low cold reset |
| rst_warm_n | output | 1 | Active-low combined warm and cold reset |

## Verification
The hardest case to reach is a request that rises again while a release is being held off. It needs a long programmed length and a second pulse placed a known number of edges into the count. The bench programs a warm length of 5 and releases the request on a falling clock edge. After three rising edges it pulses the request again and then counts edges from the second release. A cold event that follows software-programmed lengths is also driven, which shows that the defaults come back and that the warm status bits are wiped.

// File: rtl/rst_combiner_pkg.sv
package rst_combiner_pkg;

    localparam int LEN_W  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COLD_LEN = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_WARM_LEN = 2'd2;

    typedef struct packed {
        logic [1:0]       sync;
        logic [LEN_W-1:0] cnt;
        logic             done;
    } stretch_t;

    typedef struct packed {
        logic [LEN_W-1:0] cold_len;
        logic [LEN_W-1:0] warm_len;
    } cfg_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

endpackage

// File: rtl/rst_stretch.sv
module rst_stretch
    import rst_combiner_pkg::*;
(
    input  logic             clk,
    input  logic             src_act,
    input  logic [LEN_W-1:0] len,
    output logic             rst_n
);

    stretch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], 1'b1};
        if (!st_q.sync[1]) begin
            st_d.cnt = eff_len(len);
        end else if (!st_q.done) begin
            if (st_q.cnt <= LEN_W'(1)) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or posedge src_act) begin
        if (src_act) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n = st_q.done;

endmodule

// File: rtl/rst_status_log.sv
module rst_status_log #(
    parameter int                     NC       = 3,
    parameter int                     NW       = 4,
    parameter logic [NC+NW-1:0]       LOG_MASK = '1
) (
    input  logic             clk,
    input  logic             por,
    input  logic [NC+NW-1:0] req,
    input  logic             clr_we,
    input  logic [NC+NW-1:0] clr_mask,
    output logic [NC+NW-1:0] status
);

    localparam int NS = NC + NW;

    typedef struct packed {
        logic [NS-1:0] s1;
        logic [NS-1:0] s2;
        logic [NS-1:0] stat;
    } log_t;

    log_t lg_d, lg_q;

    always_comb begin
        logic [NS-1:0] seen;
        lg_d    = lg_q;
        lg_d.s1 = req;
        lg_d.s2 = lg_q.s1;
        seen    = lg_q.s2 & LOG_MASK;
        if (clr_we) begin
            lg_d.stat = lg_d.stat & ~clr_mask;
        end
        if (|lg_q.s2[NC-1:0]) begin
            lg_d.stat[NS-1:NC] = '0;
        end
        lg_d.stat = lg_d.stat | seen;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            lg_q      <= '0;
            lg_q.stat <= NS'(1);
        end else begin
            lg_q <= lg_d;
        end
    end

    assign status = lg_q.stat;

endmodule

// File: rtl/rst_cfg_regs.sv
module rst_cfg_regs
    import rst_combiner_pkg::*;
#(
    parameter int               NS       = 7,
    parameter logic [LEN_W-1:0] COLD_DEF = 8'd4,
    parameter logic [LEN_W-1:0] WARM_DEF = 8'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NS-1:0]     status,
    output logic [DATA_W-1:0] rdata,
    output logic [LEN_W-1:0]  cold_len,
    output logic [LEN_W-1:0]  warm_len
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && addr == ADDR_COLD_LEN) cfg_d.cold_len = wdata[LEN_W-1:0];
        if (we && addr == ADDR_WARM_LEN) cfg_d.warm_len = wdata[LEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.cold_len <= COLD_DEF;
            cfg_q.warm_len <= WARM_DEF;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_STATUS:   rdata[NS-1:0]    = status;
            ADDR_COLD_LEN: rdata[LEN_W-1:0] = cfg_q.cold_len;
            ADDR_WARM_LEN: rdata[LEN_W-1:0] = cfg_q.warm_len;
            default:       rdata = '0;
        endcase
    end

    assign cold_len = cfg_q.cold_len;
    assign warm_len = cfg_q.warm_len;

endmodule

// File: rtl/rst_combiner.sv
module rst_combiner
    import rst_combiner_pkg::*;
#(
    parameter int                   NUM_COLD = 3,
    parameter int                   NUM_WARM = 4,
    parameter logic [6:0]           LOG_MASK = 7'b0111111,
    parameter logic [LEN_W-1:0]     COLD_DEF = 8'd4,
    parameter logic [LEN_W-1:0]     WARM_DEF = 8'd2
) (
    input  logic                clk,
    input  logic [NUM_COLD-1:0] cold_req,
    input  logic [NUM_WARM-1:0] warm_req,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                rst_cold_n,
    output logic                rst_warm_n
);

    localparam int NS     = NUM_COLD + NUM_WARM;
    localparam int NPATH  = 2;

    logic [NS-1:0]    status_w;
    logic [LEN_W-1:0] cold_len, warm_len;
    logic [NPATH-1:0] path_src;
    logic [NPATH-1:0] path_rst_n;
    logic [LEN_W-1:0] path_len [NPATH];

    assign path_src[0] = |cold_req;
    assign path_src[1] = (|cold_req) | (|warm_req) | ~path_rst_n[0];
    assign path_len[0] = cold_len;
    assign path_len[1] = warm_len;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        rst_stretch u_stretch (
            .clk     (clk),
            .src_act (path_src[p]),
            .len     (path_len[p]),
            .rst_n   (path_rst_n[p])
        );
    end

    assign rst_cold_n = path_rst_n[0];
    assign rst_warm_n = path_rst_n[1];

    rst_status_log #(
        .NC       (NUM_COLD),
        .NW       (NUM_WARM),
        .LOG_MASK (LOG_MASK[NS-1:0])
    ) u_log (
        .clk      (clk),
        .por      (cold_req[0]),
        .req      ({warm_req, cold_req}),
        .clr_we   (reg_we && reg_addr == ADDR_STATUS),
        .clr_mask (reg_wdata[NS-1:0]),
        .status   (status_w)
    );

    rst_cfg_regs #(
        .NS       (NS),
        .COLD_DEF (COLD_DEF),
        .WARM_DEF (WARM_DEF)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_cold_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status   (status_w),
        .rdata    (reg_rdata),
        .cold_len (cold_len),
        .warm_len (warm_len)
    );

endmodule

// File: rtl/rst_combiner_chk.sv
module rst_combiner_chk #(
    parameter int NC = 3,
    parameter int NW = 4
) (
    input logic          clk,
    input logic [NC-1:0] cold_req,
    input logic [NW-1:0] warm_req,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic          rst_cold_n,
    input logic          rst_warm_n,
    input logic [NC+NW-1:0] status
);

    assert_cold_hits_both_R2: assert property (@(posedge clk) disable iff (cold_req[0])
        (|cold_req) |-> (!rst_cold_n && !rst_warm_n));

    assert_warm_hits_warm_R3: assert property (@(posedge clk) disable iff (cold_req[0])
        (|warm_req) |-> !rst_warm_n);

    assert_warm_after_cold_R4: assert property (@(posedge clk) disable iff (cold_req[0])
        !rst_cold_n |-> !rst_warm_n);

    assert_cold_release_quiet_R1: assert property (@(posedge clk) disable iff (cold_req[0])
        $rose(rst_cold_n) |-> ($past(~|cold_req) && $past(~|cold_req, 2)));

    assert_warm_release_quiet_R5: assert property (@(posedge clk) disable iff (cold_req[0])
        $rose(rst_warm_n) |-> ($past(~|{cold_req, warm_req}) &&
                               $past(~|{cold_req, warm_req}, 2) && $past(rst_cold_n)));

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (cold_req[0])
        ($past(rst_cold_n) && $past(rst_cold_n, 2) && !$past(reg_we && reg_addr == 2'd0))
        |-> ((status & $past(status)) == $past(status)));

endmodule

bind rst_combiner rst_combiner_chk #(.NC(NUM_COLD), .NW(NUM_WARM)) u_chk (
    .clk        (clk),
    .cold_req   (cold_req),
    .warm_req   (warm_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .rst_cold_n (rst_cold_n),
    .rst_warm_n (rst_warm_n),
    .status     (status_w)
);

// File: tb/rst_combiner_tb.sv
module rst_combiner_tb;

    localparam int PERIOD = 10;
    localparam int NVEC   = 5;

    typedef struct packed {
        logic [1:0] src;
        logic [7:0] len;
        logic [8:0] exp_rel;
        logic [7:0] exp_stat;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{src: 2'd0, len: 8'd1,   exp_rel: 9'd3,   exp_stat: 8'h08},
        '{src: 2'd1, len: 8'd5,   exp_rel: 9'd7,   exp_stat: 8'h10},
        '{src: 2'd2, len: 8'd0,   exp_rel: 9'd3,   exp_stat: 8'h20},
        '{src: 2'd3, len: 8'd200, exp_rel: 9'd202, exp_stat: 8'h00},
        '{src: 2'd1, len: 8'd2,   exp_rel: 9'd4,   exp_stat: 8'h10}
    };

    logic       clk = 1'b0;
    logic [2:0] cold_req = 3'b001;
    logic [3:0] warm_req = 4'b0000;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rst_cold_n, rst_warm_n;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    rst_combiner u_dut (
        .clk(clk), .cold_req(cold_req), .warm_req(warm_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    // Count rising edges after a release until each output is high.
    task automatic measure(output int kc, output int kw, output int cold_low);
        kc = 0; kw = 0; cold_low = 0;
        for (int k = 1; k <= 700; k++) begin
            @(posedge clk);
            #1;
            if (!rst_cold_n) cold_low = 1;
            if (rst_cold_n && kc == 0) kc = k;
            if (rst_warm_n && kw == 0) kw = k;
            if (kc != 0 && kw != 0) break;
        end
    endtask

    task automatic warm_pulse(input int src);
        @(negedge clk);
        warm_req[src] = 1'b1;
        #1;
        check("R3 warm out low at once", int'(rst_warm_n), 0);
        repeat (3) @(negedge clk);
        warm_req[src] = 1'b0;
    endtask

    initial begin
        #(200000 * PERIOD);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int kc, kw, cl, d;
        #1;
        check("R1 reset cold low", int'(rst_cold_n), 0);
        check("R1 reset warm low", int'(rst_warm_n), 0);
        repeat (5) @(negedge clk);
        cold_req[0] = 1'b0;
        measure(kc, kw, cl);
        check("R1 cold release edge", kc, 6);
        check("R1 warm release edge", kw, 10);
        rd(2'd0, d); check("R8 status after power-on", d, 8'h01);
        rd(2'd1, d); check("R9 cold len default", d, 4);
        rd(2'd2, d); check("R9 warm len default", d, 2);

        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 8'hFF);
            wr(2'd2, VECS[i].len);
            warm_pulse(int'(VECS[i].src));
            measure(kc, kw, cl);
            check("R4 warm release edge", kw, int'(VECS[i].exp_rel));
            check("R3 cold stayed high", cl, 0);
            rd(2'd0, d); check("R6 status logged", d, int'(VECS[i].exp_stat));
            rd(2'd2, d); check("R9 warm len kept", d, int'(VECS[i].len));
        end

        // Cold event after programming: lengths revert, warm bits wiped
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'd9);
        wr(2'd2, 8'd3);
        warm_pulse(1);
        measure(kc, kw, cl);
        rd(2'd0, d); check("R6 watchdog bit", d, 8'h10);
        @(negedge clk);
        cold_req[1] = 1'b1;
        #1;
        check("R2 cold out low at once", int'(rst_cold_n), 0);
        check("R2 warm out low at once", int'(rst_warm_n), 0);
        repeat (3) @(negedge clk);
        cold_req[1] = 1'b0;
        measure(kc, kw, cl);
        check("R2 cold release with default", kc, 6);
        check("R2 warm release with default", kw, 10);
        rd(2'd0, d); check("R8 cold wipes warm bits", d, 8'h02);
        rd(2'd1, d); check("R2 cold len restored", d, 4);
        rd(2'd2, d); check("R2 warm len restored", d, 2);

        // Partial write-one-to-clear
        warm_pulse(0);
        measure(kc, kw, cl);
        rd(2'd0, d); check("R6 two bits set", d, 8'h0A);
        wr(2'd0, 8'h02);
        rd(2'd0, d); check("R7 partial clear", d, 8'h08);

        // Re-assertion during hold-off restarts the count
        wr(2'd2, 8'd5);
        warm_pulse(2);
        repeat (3) @(posedge clk);
        #1;
        check("R5 still held mid-count", int'(rst_warm_n), 0);
        @(negedge clk);
        warm_req[2] = 1'b1;
        @(negedge clk);
        warm_req[2] = 1'b0;
        measure(kc, kw, cl);
        check("R5 restarted release edge", kw, 7);

        // Unused address
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R9 addr 3 reads zero", d, 0);
        rd(2'd1, d); check("R9 cold len untouched", d, 4);
        rd(2'd2, d); check("R9 warm len untouched", d, 5);
        rd(2'd0, d); check("R9 status untouched", d, 8'h28);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule